// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block is a hardware state machine that turns one video power domain on or off when asked. It drives the isolation enable, the control of the main power switch, two banks of memory power-down bits plus a small group of extra memory power-down bits, a domain reset, and two clock enables: a core clock and a bus clock. Every wait is measured by a cycle counter whose length is the number of microseconds multiplied by the parameter `CYCLES_PER_US`.

The two sequences are ordered differently. Switching off isolates the domain first, then walks the memory bits one at a time. After that it opens the power switch and waits for the supply to settle before it stops the clocks. Switching on closes the switch first and walks the memory bits in the same order. It then pulses the reset around the release of isolation and starts the clocks last. While a sequence runs, `busy_o` is high and any new request is dropped. A request for the state the domain is already in does nothing.

Top module: `pwrdom_seq`

## Requirements
- R1: During reset the state is loaded from `sw_closed_i`.
  - When it is 1, the domain starts powered: isolation 0, switch closed, all memory bits 0, both clocks on.
  - When it is 0, the domain starts off: isolation 1, `sw_open_o` 1, both clocks off, and every memory bit the sequencer controls set to 1. That is bank value 0xAAAAAAAA and extra value 0xFF.
  - Reset is synchronous and `dom_rst_o` is 0.
- R2: A power-down request (`down_req_i` or `halt_req_i`) sampled at clock edge e0 while the domain is idle and powered sets `iso_en_o` at e0. Isolation stays 1 until the domain is powered up again.
- R3: The memory steps run in a fixed order.
  - Step j (0..39) happens at edge e0 + 20·C + 5·C·j, where C = `CYCLES_PER_US`.
  - Steps 0..15 act on bank A bit 2j+1, steps 16..31 on bank B bit 2(j−16)+1, and steps 32..39 on extra output bit j−32 (memory index 8..15).
  - Exactly one bit changes per step: it is set on power-down and cleared on power-up. Even-numbered bank bits never change.
- R4: On power-down, `sw_open_o` rises at e0 + 240·C, which is 25·C after the last memory step. `clk_core_en_o` falls 20000·C cycles later, and `clk_bus_en_o` falls on the following edge.
- R5: On power-up from edge e0:
  - `sw_open_o` falls at e0.
  - The memory steps follow R3.
  - `dom_rst_o` rises at e0 + 240·C.
  - `iso_en_o` falls one edge later, and `dom_rst_o` falls one edge after that.
  - `clk_core_en_o` rises on the next edge and `clk_bus_en_o` on the edge after it.
- R6: `busy_o` rises at e0. `busy_o` and the change of `powered_o` both happen on the edge of the final clock-enable change, and at no other time.
- R7: Any request sampled while `busy_o` is high is ignored. The running sequence keeps its schedule.
- R8: An up request while powered, or a down/halt request while unpowered, changes no output, and `busy_o` stays 0.
- R9: `halt_req_i` starts the power-down only while the domain is powered and idle. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| up_req_i | input | 1 | Power-up request |
| down_req_i | input | 1 | Power-down request |
| halt_req_i | input | 1 | Shutdown request, acts only when powered |
| sw_closed_i | input | 1 | Power-switch status, sampled during reset |
| iso_en_o | output | 1 | Isolation enable |
| sw_open_o | output | 1 | 1 opens the main power switch |
| mem_pd_a_o | output | 32 | Memory power-down bank A |
| mem_pd_b_o | output | 32 | Memory power-down bank B |
| mem_pd_x_o | output | 8 | Extra memory power-down bits (index 8..15) |
| dom_rst_o | output | 1 | Domain reset, active high |
| clk_core_en_o | output | 1 | Core clock enable |
| clk_bus_en_o | output | 1 | Bus clock enable |
| busy_o | output | 1 | Sequence in progress |
| powered_o | output | 1 | Domain powered |

## Verification
The hardest state to reach is a request arriving in the middle of a sequence: deep inside the memory walk, or during the 20000-cycle settling wait. It must be shown that such a request neither restarts nor reverses the sequence. The bench uses C = 1 and pulses the opposite request and the shutdown request at chosen cycles inside both windows. A behavioural reference model, which keeps its own event schedule for each sequence, is compared with every output on every cycle. A second reset with the switch reported closed reaches the powered initial state without running a power-up sequence first.

// File: rtl/pwrdom_pkg.sv
package pwrdom_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DN_MEM,
        ST_DN_SW,
        ST_DN_CLKC,
        ST_DN_CLKB,
        ST_UP_MEM,
        ST_UP_RSTA,
        ST_UP_ISO,
        ST_UP_RSTD,
        ST_UP_CLKC,
        ST_UP_CLKB
    } seq_state_e;
endpackage

// File: rtl/pwrdom_timer.sv
module pwrdom_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwrdom_mem_map.sv
module pwrdom_mem_map #(
    parameter int FIELDS  = 16,
    parameter int FIELD_W = 2,
    parameter int XBITS   = 8,
    parameter int IDX_W   = 6
) (
    input  logic [IDX_W-1:0]          idx_i,
    output logic [FIELDS*FIELD_W-1:0] mask_a_o,
    output logic [FIELDS*FIELD_W-1:0] mask_b_o,
    output logic [XBITS-1:0]          mask_x_o
);
    localparam int BW = FIELDS * FIELD_W;

    for (genvar b = 0; b < BW; b++) begin : g_bank
        if ((b % FIELD_W) == FIELD_W - 1) begin : g_top
            assign mask_a_o[b] = (idx_i == IDX_W'(b / FIELD_W));
            assign mask_b_o[b] = (idx_i == IDX_W'(FIELDS + b / FIELD_W));
        end else begin : g_low
            assign mask_a_o[b] = 1'b0;
            assign mask_b_o[b] = 1'b0;
        end
    end

    for (genvar k = 0; k < XBITS; k++) begin : g_extra
        assign mask_x_o[k] = (idx_i == IDX_W'(2 * FIELDS + k));
    end
endmodule

// File: rtl/pwrdom_seq.sv
module pwrdom_seq
    import pwrdom_pkg::*;
#(
    parameter int CYCLES_PER_US = 1,
    parameter int ISO_US        = 20,
    parameter int STEP_US       = 5,
    parameter int TAIL_US       = 20,
    parameter int SETTLE_US     = 20000,
    parameter int FIELDS        = 16,
    parameter int FIELD_W       = 2,
    parameter int XBITS         = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      up_req_i,
    input  logic                      down_req_i,
    input  logic                      halt_req_i,
    input  logic                      sw_closed_i,
    output logic                      iso_en_o,
    output logic                      sw_open_o,
    output logic [FIELDS*FIELD_W-1:0] mem_pd_a_o,
    output logic [FIELDS*FIELD_W-1:0] mem_pd_b_o,
    output logic [XBITS-1:0]          mem_pd_x_o,
    output logic                      dom_rst_o,
    output logic                      clk_core_en_o,
    output logic                      clk_bus_en_o,
    output logic                      busy_o,
    output logic                      powered_o
);
    localparam int BW     = FIELDS * FIELD_W;
    localparam int STEPS  = 2 * FIELDS + XBITS;
    localparam int IDX_W  = $clog2(STEPS);
    localparam int C_ISO  = ISO_US * CYCLES_PER_US;
    localparam int C_STEP = STEP_US * CYCLES_PER_US;
    localparam int C_TAIL = (STEP_US + TAIL_US) * CYCLES_PER_US;
    localparam int C_SW   = SETTLE_US * CYCLES_PER_US;
    localparam int C_MAX  = (C_SW > C_TAIL) ? ((C_SW > C_ISO) ? C_SW : C_ISO)
                                            : ((C_TAIL > C_ISO) ? C_TAIL : C_ISO);
    localparam int TMR_W  = $clog2(C_MAX + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

    function automatic logic [BW-1:0] upper_bits();
        logic [BW-1:0] v;
        v = '0;
        for (int f = 0; f < FIELDS; f++) begin
            v[f*FIELD_W + FIELD_W - 1] = 1'b1;
        end
        return v;
    endfunction

    localparam logic [BW-1:0] OFF_BANK = upper_bits();

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             iso;
        logic             sw_open;
        logic [BW-1:0]    bank_a;
        logic [BW-1:0]    bank_b;
        logic [XBITS-1:0] xbits;
        logic             drst;
        logic             clk_core;
        logic             clk_bus;
        logic             pwr;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic [BW-1:0]    mask_a, mask_b;
    logic [XBITS-1:0] mask_x;
    logic             set_val;

    pwrdom_timer #(.W(TMR_W)) timer_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    pwrdom_mem_map #(
        .FIELDS (FIELDS),
        .FIELD_W(FIELD_W),
        .XBITS  (XBITS),
        .IDX_W  (IDX_W)
    ) map_i (
        .idx_i    (r_q.idx),
        .mask_a_o (mask_a),
        .mask_b_o (mask_b),
        .mask_x_o (mask_x)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        set_val  = (r_q.st == ST_DN_MEM);
        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.pwr && (down_req_i || halt_req_i)) begin
                    r_d.iso  = 1'b1;
                    r_d.idx  = '0;
                    r_d.st   = ST_DN_MEM;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(C_ISO - 1);
                end else if (!r_q.pwr && up_req_i) begin
                    r_d.sw_open = 1'b0;
                    r_d.idx     = '0;
                    r_d.st      = ST_UP_MEM;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(C_ISO - 1);
                end
            end
            ST_DN_MEM, ST_UP_MEM: begin
                if (tmr_zero) begin
                    r_d.bank_a = set_val ? (r_q.bank_a | mask_a) : (r_q.bank_a & ~mask_a);
                    r_d.bank_b = set_val ? (r_q.bank_b | mask_b) : (r_q.bank_b & ~mask_b);
                    r_d.xbits  = set_val ? (r_q.xbits | mask_x) : (r_q.xbits & ~mask_x);
                    tmr_load   = 1'b1;
                    if (r_q.idx == LAST_IDX) begin
                        tmr_val = TMR_W'(C_TAIL - 1);
                        r_d.st  = set_val ? ST_DN_SW : ST_UP_RSTA;
                    end else begin
                        tmr_val = TMR_W'(C_STEP - 1);
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_DN_SW: begin
                if (tmr_zero) begin
                    r_d.sw_open = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(C_SW - 1);
                    r_d.st      = ST_DN_CLKC;
                end
            end
            ST_DN_CLKC: begin
                if (tmr_zero) begin
                    r_d.clk_core = 1'b0;
                    r_d.st       = ST_DN_CLKB;
                end
            end
            ST_DN_CLKB: begin
                r_d.clk_bus = 1'b0;
                r_d.pwr     = 1'b0;
                r_d.st      = ST_IDLE;
            end
            ST_UP_RSTA: begin
                if (tmr_zero) begin
                    r_d.drst = 1'b1;
                    r_d.st   = ST_UP_ISO;
                end
            end
            ST_UP_ISO: begin
                r_d.iso = 1'b0;
                r_d.st  = ST_UP_RSTD;
            end
            ST_UP_RSTD: begin
                r_d.drst = 1'b0;
                r_d.st   = ST_UP_CLKC;
            end
            ST_UP_CLKC: begin
                r_d.clk_core = 1'b1;
                r_d.st       = ST_UP_CLKB;
            end
            ST_UP_CLKB: begin
                r_d.clk_bus = 1'b1;
                r_d.pwr     = 1'b1;
                r_d.st      = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.st       <= ST_IDLE;
            r_q.idx      <= '0;
            r_q.pwr      <= sw_closed_i;
            r_q.iso      <= !sw_closed_i;
            r_q.sw_open  <= !sw_closed_i;
            r_q.bank_a   <= sw_closed_i ? '0 : OFF_BANK;
            r_q.bank_b   <= sw_closed_i ? '0 : OFF_BANK;
            r_q.xbits    <= sw_closed_i ? '0 : '1;
            r_q.drst     <= 1'b0;
            r_q.clk_core <= sw_closed_i;
            r_q.clk_bus  <= sw_closed_i;
        end else begin
            r_q <= r_d;
        end
    end

    assign iso_en_o      = r_q.iso;
    assign sw_open_o     = r_q.sw_open;
    assign mem_pd_a_o    = r_q.bank_a;
    assign mem_pd_b_o    = r_q.bank_b;
    assign mem_pd_x_o    = r_q.xbits;
    assign dom_rst_o     = r_q.drst;
    assign clk_core_en_o = r_q.clk_core;
    assign clk_bus_en_o  = r_q.clk_bus;
    assign busy_o        = (r_q.st != ST_IDLE);
    assign powered_o     = r_q.pwr;

    logic [2*BW+XBITS-1:0] mem_all;
    assign mem_all = {r_q.bank_a, r_q.bank_b, r_q.xbits};

    // R2 / R5: isolation is released only while the switch is closed
    p_iso_covers_switch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !iso_en_o |-> !sw_open_o);

    // R3: at most one memory control bit moves per cycle
    p_one_mem_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(mem_all ^ $past(mem_all)) <= 1);

    // R4: bus clock stops only after the core clock has stopped
    p_bus_off_after_core_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(clk_bus_en_o) |-> (!clk_core_en_o && !$past(clk_core_en_o)));

    // R5: bus clock starts only after the core clock is running
    p_bus_on_after_core_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_bus_en_o) |-> $past(clk_core_en_o));

    // R5: domain reset is pulsed only inside a sequence
    p_rst_inside_seq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dom_rst_o |-> busy_o);

    // R6: powered flag moves only when busy drops
    p_pwr_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(powered_o) |-> ($past(busy_o) && !busy_o));

    // R8: while idle, no output moves
    p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !$past(busy_o)) |->
            ($stable(mem_all) && $stable(iso_en_o) && $stable(sw_open_o) &&
             $stable(clk_core_en_o) && $stable(clk_bus_en_o)));
endmodule

// File: tb/pwrdom_seq_tb.sv
`timescale 1ns/1ps
module pwrdom_seq_tb_top;
    localparam int C        = 1;
    localparam int T_ISO    = 20 * C;
    localparam int T_STEP   = 5 * C;
    localparam int MEM_END  = T_ISO + 39 * T_STEP + 25 * C;
    localparam int T_SW     = 20000 * C;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_req = 1'b0, down_req = 1'b0, halt_req = 1'b0, sw_closed = 1'b0;
    logic iso, swo, drst, cclk, bclk, busy, pwr;
    logic [31:0] ba, bb;
    logic [7:0]  bx;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;
    string focus = "";

    always #2 clk = ~clk;

    pwrdom_seq #(.CYCLES_PER_US(C)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .up_req_i(up_req), .down_req_i(down_req),
        .halt_req_i(halt_req), .sw_closed_i(sw_closed),
        .iso_en_o(iso), .sw_open_o(swo), .mem_pd_a_o(ba), .mem_pd_b_o(bb),
        .mem_pd_x_o(bx), .dom_rst_o(drst), .clk_core_en_o(cclk),
        .clk_bus_en_o(bclk), .busy_o(busy), .powered_o(pwr)
    );

    // behavioural reference model
    logic m_iso, m_swo, m_rst, m_cc, m_cb, m_busy, m_pwr, m_down;
    logic [31:0] m_ba, m_bb;
    logic [7:0]  m_bx;
    int n;
    string m_tag = "R1";

    task automatic set_mem(input int j, input logic v);
        if (j < 16)      m_ba[2*j+1] = v;
        else if (j < 32) m_bb[2*(j-16)+1] = v;
        else             m_bx[j-32] = v;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pwr = sw_closed; m_iso = !sw_closed; m_swo = !sw_closed;
            m_ba = sw_closed ? 32'h0 : 32'hAAAA_AAAA;
            m_bb = sw_closed ? 32'h0 : 32'hAAAA_AAAA;
            m_bx = sw_closed ? 8'h00 : 8'hFF;
            m_rst = 1'b0; m_cc = sw_closed; m_cb = sw_closed;
            m_busy = 1'b0; n = 0; m_tag = "R1";
            cmp_en = 1'b1;
        end else begin
            if (m_busy) n++;
            else if (m_pwr && (down_req || halt_req)) begin
                m_busy = 1'b1; m_down = 1'b1; n = 0;
            end else if (!m_pwr && up_req) begin
                m_busy = 1'b1; m_down = 1'b0; n = 0;
            end else m_tag = "R8";
            if (m_busy) begin
                if (n >= T_ISO && (n - T_ISO) % T_STEP == 0 && (n - T_ISO) / T_STEP < 40) begin
                    set_mem((n - T_ISO) / T_STEP, m_down);
                    m_tag = "R3";
                end
                if (m_down) begin
                    if (n == 0) begin m_iso = 1'b1; m_tag = "R2"; end
                    if (n == MEM_END) begin m_swo = 1'b1; m_tag = "R4"; end
                    if (n == MEM_END + T_SW) m_cc = 1'b0;
                    if (n == MEM_END + T_SW + 1) begin
                        m_cb = 1'b0; m_busy = 1'b0; m_pwr = 1'b0; m_tag = "R6";
                    end
                end else begin
                    if (n == 0) begin m_swo = 1'b0; m_tag = "R5"; end
                    if (n == MEM_END) m_rst = 1'b1;
                    if (n == MEM_END + 1) m_iso = 1'b0;
                    if (n == MEM_END + 2) m_rst = 1'b0;
                    if (n == MEM_END + 3) m_cc = 1'b1;
                    if (n == MEM_END + 4) begin
                        m_cb = 1'b1; m_busy = 1'b0; m_pwr = 1'b1; m_tag = "R6";
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            logic [78:0] a, e;
            a = {iso, swo, ba, bb, bx, drst, cclk, bclk, busy, pwr};
            e = {m_iso, m_swo, m_ba, m_bb, m_bx, m_rst, m_cc, m_cb, m_busy, m_pwr};
            chk(a === e, (focus != "") ? focus : m_tag, 128'(a), 128'(e));
        end
    end

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) up_req = 1'b1;
        else if (which == 1) down_req = 1'b1;
        else halt_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0; down_req = 1'b0; halt_req = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R6 watchdog: actual=busy expected=idle");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        sw_closed = 1'b0; rst_n = 1'b0;
        wait_cyc(3); rst_n = 1'b1;
        wait_cyc(5);
        focus = "R8"; pulse(1);                        // down while off: no effect
        focus = "R9"; pulse(2); wait_cyc(5);           // halt while off: ignored
        focus = ""; pulse(0); wait_cyc(100);           // power up
        focus = "R7"; pulse(1); pulse(2); pulse(0);    // mid memory walk
        focus = ""; wait_cyc(200);
        chk(pwr === 1'b1, "R6", 128'(pwr), 128'(1));
        focus = "R8"; pulse(0); wait_cyc(5);           // up while on
        focus = ""; pulse(1); wait_cyc(300);           // power down
        focus = "R7"; pulse(0); pulse(2); pulse(1);    // inside settling wait
        focus = ""; wait_cyc(20000);
        chk(pwr === 1'b0, "R6", 128'(pwr), 128'(0));
        chk(bx === 8'hFF, "R3", 128'(bx), 128'(8'hFF));
        pulse(0); wait_cyc(300);
        focus = "R9"; pulse(2); wait_cyc(20300);       // shutdown while on
        chk(pwr === 1'b0 && swo === 1'b1, "R9", 128'({pwr, swo}), 128'(2'b01));
        focus = "";
        rst_n = 1'b0; sw_closed = 1'b1; wait_cyc(3); rst_n = 1'b1;
        focus = "R1"; wait_cyc(5);
        chk(pwr === 1'b1 && cclk === 1'b1 && ba === 32'h0, "R1", 128'({pwr, cclk, ba}), 128'({2'b11, 32'h0}));
        focus = ""; pulse(1); wait_cyc(20300);
        chk(ba === 32'hAAAA_AAAA && bb === 32'hAAAA_AAAA, "R4", 128'({ba, bb}), 128'({32'hAAAA_AAAA, 32'hAAAA_AAAA}));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule